// File: doc/BRIEF.md
# Sixteen-Function ALU with Condition Flags

This block is the arithmetic and logic unit of a small 32-bit microcoded RISC datapath. Two operands and a 4-bit function code go in; a 32-bit result comes out in the same cycle, combinationally. Besides the ordinary logic, add and shift operations, it provides the helpers a microprogram relies on. These are fixed left shifts by 2 and by 10, extraction of a 13-bit immediate with zero or sign fill, increments by one and by four, and a right shift by 5 that keeps the sign.

Four condition flags are kept in a small register inside the block: negative, zero, overflow and carry. The register captures new flags on a clock edge only when the set-condition-codes strobe is high and the function is one of the four flag-setting codes. Any other function, or a low strobe, leaves the flags as they were.

A single barrel shifter serves every shift, and a single adder serves every sum. The function code picks the direction, fill and amount for the shifter, and the second operand for the adder.

Top module: `opsel_alu`

## Requirements
- R1: Codes 0 and 5 give A AND B, codes 1 and 6 give A OR B, and codes 2 and 7 give NOT(A OR B).
- R2: Codes 3 and 8 give A + B modulo 2^32.
- R3: Code 4 gives A shifted right logically by B[4:0], filling with zeros. B[31:5] has no effect on the result.
- R4: Code 9 gives A shifted left by 2, and code 10 gives A shifted left by 10, both filling with zeros.
- R5: Code 11 gives A[12:0] with bits 31..13 cleared. Code 12 gives A[12:0] with bit 12 copied into bits 31..13.
- R6: Code 13 gives A + 1, and code 14 gives A + 4, both modulo 2^32.
- R7: Code 15 gives A shifted right by 5, with A[31] copied into the five vacated top bits.
- R8: Codes 9 to 15 use only A; the value on B has no effect on the result.
- R9: The flags change on a rising clock edge only when the strobe is high and the code is 0, 1, 2 or 3. Otherwise they hold.
- R10: On capture, n equals result bit 31 and z is 1 exactly when the result is zero. For code 3, c is the carry out of bit 31 and v is the signed overflow. For codes 0 to 2, v and c are cleared.
- R11: An active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| fn_i | input | 4 | Function code |
| scc_i | input | 1 | Set-condition-codes strobe |
| res_o | output | 32 | Combinational result |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_v_o | output | 1 | Registered overflow flag |
| flag_c_o | output | 1 | Registered carry flag |

## Verification
The hardest case to reach is the flag register refusing an update. That requires the strobe to be high on a code that computes a carry or a zero but is not a flag-setting code. The stimulus first loads a distinctive flag pattern with a flag-setting add. It then issues a plain add that would produce zero with a carry, and after that a flag-setting add with the strobe low, reading the flags after each edge. Carry and overflow clearing is reached the same way: a logic flag-setting operation follows an add that left both flags set.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [3:0] {
    FN_ANDCC  = 4'h0,
    FN_ORCC   = 4'h1,
    FN_NORCC  = 4'h2,
    FN_ADDCC  = 4'h3,
    FN_SRL    = 4'h4,
    FN_AND    = 4'h5,
    FN_OR     = 4'h6,
    FN_NOR    = 4'h7,
    FN_ADD    = 4'h8,
    FN_LSH2   = 4'h9,
    FN_LSH10  = 4'hA,
    FN_IMMZ   = 4'hB,
    FN_IMMS   = 4'hC,
    FN_INC1   = 4'hD,
    FN_INC4   = 4'hE,
    FN_ASR5   = 4'hF
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;

  // Flag-setting codes occupy the lowest quarter of the code space.
  function automatic logic fn_sets_flags(input logic [3:0] f);
    return (f[3:2] == 2'b00);
  endfunction

endpackage

// File: rtl/opsel_shift_unit.sv
module opsel_shift_unit #(
  parameter int W   = 32,
  parameter int SAW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SAW-1:0] amt_i,
  input  logic           left_i,
  input  logic           arith_i,
  output logic [W-1:0]   data_o
);

  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stg [0:SAW];
  logic         fill;

  // Left shifts reuse the right-shifting network by mirroring the word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stg[SAW][W-1-i];
  end

  assign fill   = arith_i & ~left_i & data_i[W-1];
  assign stg[0] = left_i ? rev_in : data_i;

  for (genvar s = 0; s < SAW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
  end

  assign data_o = left_i ? rev_out : stg[SAW];

endmodule

// File: rtl/opsel_add_unit.sv
module opsel_add_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic [W:0] wide;

  always_comb begin
    wide   = {1'b0, x_i} + {1'b0, y_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    ovf_o  = (x_i[W-1] == y_i[W-1]) && (wide[W-1] != x_i[W-1]);
  end

endmodule

// File: rtl/opsel_flag_reg.sv
module opsel_flag_reg
  import opsel_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);

  logic       rst_meta;
  logic       rst_sync;
  alu_flags_t flags_q;
  alu_flags_t flags_d;

  // Reset asserts at once and deasserts two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    flags_d = flags_q;
    if (en_i) flags_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) flags_q <= '0;
    else           flags_q <= flags_d;
  end

  assign q_o = flags_q;

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fn_i,
  input  logic         scc_i,
  output logic [W-1:0] res_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_v_o,
  output logic         flag_c_o
);

  localparam int SAW = $clog2(W);
  localparam logic [SAW-1:0] AMT_L2  = SAW'(2);
  localparam logic [SAW-1:0] AMT_L10 = SAW'(10);
  localparam logic [SAW-1:0] AMT_R5  = SAW'(5);
  localparam logic [W-1:0]   ONE     = W'(1);
  localparam logic [W-1:0]   FOUR    = W'(4);

  alu_fn_e        fn;
  logic [SAW-1:0] sh_amt;
  logic           sh_left;
  logic           sh_arith;
  logic [W-1:0]   sh_out;
  logic [W-1:0]   add_y;
  logic [W-1:0]   add_sum;
  logic           add_cout;
  logic           add_ovf;
  alu_flags_t     flags_new;
  alu_flags_t     flags_cur;

  assign fn = alu_fn_e'(fn_i);

  // Shifter control: direction, fill and amount by function.
  always_comb begin
    sh_amt   = b_i[SAW-1:0];
    sh_left  = 1'b0;
    sh_arith = 1'b0;
    unique case (fn)
      FN_LSH2:  begin sh_amt = AMT_L2;  sh_left = 1'b1; end
      FN_LSH10: begin sh_amt = AMT_L10; sh_left = 1'b1; end
      FN_ASR5:  begin sh_amt = AMT_R5;  sh_arith = 1'b1; end
      default:  ;
    endcase
  end

  opsel_shift_unit #(.W(W), .SAW(SAW)) u_shift (
    .data_i  (a_i),
    .amt_i   (sh_amt),
    .left_i  (sh_left),
    .arith_i (sh_arith),
    .data_o  (sh_out)
  );

  // Adder second operand.
  always_comb begin
    unique case (fn)
      FN_INC1: add_y = ONE;
      FN_INC4: add_y = FOUR;
      default: add_y = b_i;
    endcase
  end

  opsel_add_unit #(.W(W)) u_add (
    .x_i    (a_i),
    .y_i    (add_y),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .ovf_o  (add_ovf)
  );

  // Result selection.
  always_comb begin
    unique case (fn)
      FN_ANDCC, FN_AND: res_o = a_i & b_i;
      FN_ORCC,  FN_OR:  res_o = a_i | b_i;
      FN_NORCC, FN_NOR: res_o = ~(a_i | b_i);
      FN_ADDCC, FN_ADD,
      FN_INC1,  FN_INC4: res_o = add_sum;
      FN_IMMZ:  res_o = {{(W-IMM_W){1'b0}}, a_i[IMM_W-1:0]};
      FN_IMMS:  res_o = {{(W-IMM_W){a_i[IMM_W-1]}}, a_i[IMM_W-1:0]};
      default:  res_o = sh_out;
    endcase
  end

  always_comb begin
    flags_new.n = res_o[W-1];
    flags_new.z = ~|res_o;
    flags_new.v = (fn == FN_ADDCC) & add_ovf;
    flags_new.c = (fn == FN_ADDCC) & add_cout;
  end

  opsel_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (scc_i & fn_sets_flags(fn_i)),
    .d_i   (flags_new),
    .q_o   (flags_cur)
  );

  assign flag_n_o = flags_cur.n;
  assign flag_z_o = flags_cur.z;
  assign flag_v_o = flags_cur.v;
  assign flag_c_o = flags_cur.c;

endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [3:0]   fn_i,
  input logic         scc_i,
  input logic [W-1:0] res_o,
  input logic         flag_n_o,
  input logic         flag_z_o,
  input logic         flag_v_o,
  input logic         flag_c_o
);

  logic capture;
  assign capture = scc_i && (fn_i[3:2] == 2'b00);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o}));

  p_neg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (flag_n_o == $past(res_o[W-1])));

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (flag_z_o == ($past(res_o) == '0)));

  p_logic_vc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && fn_i != 4'h3) |=> (!flag_v_o && !flag_c_o));

  p_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 4'hC) |-> (res_o[W-1:IMM_W] == {(W-IMM_W){a_i[IMM_W-1]}}));

  p_asr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 4'hF) |-> (res_o[W-1:W-5] == {5{a_i[W-1]}}));

  p_unary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i >= 4'h9 && $stable(fn_i) && $stable(a_i)) |-> $stable(res_o));

endmodule

bind opsel_alu opsel_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_i      (a_i),
  .b_i      (b_i),
  .fn_i     (fn_i),
  .scc_i    (scc_i),
  .res_o    (res_o),
  .flag_n_o (flag_n_o),
  .flag_z_o (flag_z_o),
  .flag_v_o (flag_v_o),
  .flag_c_o (flag_c_o)
);

// File: tb/sim_opsel_alu.sv
`timescale 1ns/1ps
module sim_opsel_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] a_i, b_i, res_o;
  logic [3:0]  fn_i;
  logic        scc_i;
  logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  opsel_alu u0 (
    .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .fn_i(fn_i),
    .scc_i(scc_i), .res_o(res_o), .flag_n_o(flag_n_o),
    .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flags();
    return {28'd0, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
  endfunction

  task automatic drive(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                       input logic s);
    @(negedge clk);
    fn_i = f; a_i = a; b_i = b; scc_i = s;
    #1;
  endtask

  // Apply with strobe, let one rising edge pass, then compare flags {n,z,v,c}.
  task automatic flag_step(input string tag, input logic [3:0] f, input logic [31:0] a,
                           input logic [31:0] b, input logic s, input logic [3:0] exp);
    drive(f, a, b, s);
    @(posedge clk);
    #1;
    scc_i = 1'b0;
    check(tag, flags(), {28'd0, exp});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; scc_i = 1'b0; fn_i = 4'h5; a_i = '0; b_i = '0;
    repeat (2) @(negedge clk);
    check("R11 flags cleared in reset", flags(), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 flags zero after release", flags(), 32'h0);
  endtask

  task automatic t_logic();
    logic [31:0] a = 32'hF0F0_1234, b = 32'h0FF0_00FF;
    drive(4'h0, a, b, 0); check("R1 ANDCC", res_o, 32'h00F0_0034);
    drive(4'h5, a, b, 0); check("R1 AND",   res_o, 32'h00F0_0034);
    drive(4'h1, a, b, 0); check("R1 ORCC",  res_o, 32'hFFF0_12FF);
    drive(4'h6, a, b, 0); check("R1 OR",    res_o, 32'hFFF0_12FF);
    drive(4'h2, a, b, 0); check("R1 NORCC", res_o, 32'h000F_ED00);
    drive(4'h7, a, b, 0); check("R1 NOR",   res_o, 32'h000F_ED00);
  endtask

  task automatic t_add();
    drive(4'h3, 32'h7FFF_FFFF, 32'h1, 0); check("R2 ADDCC", res_o, 32'h8000_0000);
    drive(4'h8, 32'hFFFF_FFFF, 32'h1, 0); check("R2 ADD wrap", res_o, 32'h0);
    drive(4'h8, 32'h1234_5678, 32'h1111_1111, 0); check("R2 ADD", res_o, 32'h2345_6789);
  endtask

  task automatic t_srl();
    drive(4'h4, 32'h8000_0000, 32'h0000_001F, 0); check("R3 SRL 31", res_o, 32'h1);
    drive(4'h4, 32'h8000_0000, 32'hFFFF_FFE4, 0); check("R3 SRL high B ignored", res_o, 32'h0800_0000);
    drive(4'h4, 32'h8000_0000, 32'h0000_0020, 0); check("R3 SRL by 0", res_o, 32'h8000_0000);
  endtask

  task automatic t_lshift();
    drive(4'h9, 32'hC000_0001, 32'h0, 0); check("R4 LSHIFT2", res_o, 32'h0000_0004);
    drive(4'hA, 32'h0012_3456, 32'h0, 0); check("R4 LSHIFT10", res_o, 32'h48D1_5800);
  endtask

  task automatic t_field();
    drive(4'hB, 32'hFFFF_F123, 32'h0, 0); check("R5 zero-filled field", res_o, 32'h0000_1123);
    drive(4'hC, 32'h0000_1123, 32'h0, 0); check("R5 sign-extended negative", res_o, 32'hFFFF_F123);
    drive(4'hC, 32'hFFFF_0FFF, 32'h0, 0); check("R5 sign-extended positive", res_o, 32'h0000_0FFF);
  endtask

  task automatic t_inc();
    drive(4'hD, 32'hFFFF_FFFF, 32'h0, 0); check("R6 INC wrap", res_o, 32'h0);
    drive(4'hE, 32'h0000_1000, 32'h0, 0); check("R6 INCPC", res_o, 32'h0000_1004);
    drive(4'hE, 32'hFFFF_FFFE, 32'h0, 0); check("R6 INCPC wrap", res_o, 32'h0000_0002);
  endtask

  task automatic t_asr();
    drive(4'hF, 32'h8000_0000, 32'h0, 0); check("R7 RSHIFT5 negative", res_o, 32'hFC00_0000);
    drive(4'hF, 32'h7FFF_FFE0, 32'h0, 0); check("R7 RSHIFT5 positive", res_o, 32'h03FF_FFFF);
  endtask

  task automatic t_unary_b();
    drive(4'h9, 32'h1, 32'hFFFF_FFFF, 0); check("R8 LSHIFT2 with B set", res_o, 32'h4);
    drive(4'hD, 32'h10, 32'h0000_0123, 0); check("R8 INC with B set", res_o, 32'h11);
    drive(4'hF, 32'h8000_0000, 32'h0000_001F, 0); check("R8 RSHIFT5 with B set", res_o, 32'hFC00_0000);
    drive(4'hB, 32'h0000_0ABC, 32'hFFFF_FFFF, 0); check("R8 SIMM13 with B set", res_o, 32'h0000_0ABC);
  endtask

  task automatic t_flags();
    flag_step("R10 ADDCC overflow",       4'h3, 32'h7FFF_FFFF, 32'h1, 1, 4'b1010);
    flag_step("R9 plain ADD holds",       4'h8, 32'hFFFF_FFFF, 32'h1, 1, 4'b1010);
    flag_step("R9 strobe low holds",      4'h3, 32'hFFFF_FFFF, 32'h1, 0, 4'b1010);
    flag_step("R9 INC with strobe holds", 4'hD, 32'hFFFF_FFFF, 32'h0, 1, 4'b1010);
    flag_step("R10 ANDCC zero",           4'h0, 32'h0, 32'hFFFF_FFFF, 1, 4'b0100);
    flag_step("R10 ORCC negative",        4'h1, 32'h8000_0000, 32'h0, 1, 4'b1000);
    flag_step("R10 NORCC all ones",       4'h2, 32'h0, 32'h0, 1, 4'b1000);
    flag_step("R10 ADDCC carry+ovf+zero", 4'h3, 32'h8000_0000, 32'h8000_0000, 1, 4'b0111);
    flag_step("R10 ANDCC clears v,c",     4'h0, 32'h1, 32'h1, 1, 4'b0000);
    flag_step("R10 ADDCC carry only",     4'h3, 32'hFFFF_FFFF, 32'h2, 1, 4'b0001);
  endtask

  task automatic t_reset_mid();
    flag_step("R10 ADDCC set n", 4'h3, 32'h8000_0000, 32'h1, 1, 4'b1000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 async clear mid-run", flags(), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; scc_i = 1'b0; fn_i = 4'h5; a_i = '0; b_i = '0;
    t_reset();
    t_logic();
    t_add();
    t_srl();
    t_lshift();
    t_field();
    t_inc();
    t_asr();
    t_unary_b();
    t_flags();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule